// File: doc/BRIEF.md
# SPI Slave Length-Prefixed Packet Exchanger

This block is a full-duplex SPI slave. During one chip-select session it trades one variable-length packet in each direction with the bus master. Each packet is a run of 16-bit words. Word 0 holds the packet length in words, counting the length word itself but not the checksum. A 32-bit checksum follows the data words. The bus runs with the clock idle low. MISO changes on the rising clock edge and MOSI is sampled on the falling edge. The three input pins are synchronised into the system clock domain before use.

When select falls, the slave captures the length word of its local transmit buffer and clamps it. It then streams that packet, then its checksum, then zero words for as long as the master keeps clocking. The transmit buffer is read through a word-wide asynchronous read port.

At the same time the slave decodes the master's length word and writes the incoming data words into a receive buffer through a write port. It collects the master's checksum. When select rises it reports the outcome: a one-cycle `done` pulse, plus the held levels `crc_ok` and `truncated`. Select release is the only end-of-session and timeout mechanism. A clock pulse lost in one session therefore cannot disturb the next one.

The session controller has three states:
- SES_IDLE goes to SES_LIVE when select falls.
- SES_LIVE goes to SES_CLOSE when select rises.
- SES_CLOSE goes back to SES_IDLE unconditionally.

The transmit path steps through TX_BODY, TX_SUM_HI, TX_SUM_LO and TX_PAD. At each word boundary it moves to the next state, and it stays in TX_PAD. The receive path steps through RX_HEAD, RX_BODY, RX_SUM_HI, RX_SUM_LO and RX_TAIL. It skips RX_BODY when the length is one word.

Top module: `spi_pkt_slave`

## Requirements
- R1: After reset, `done`, `crc_ok`, `truncated`, `rx_we` and `spi_miso` are all 0.
- R2: On select fall, the slave sends its packet MSB first. It shifts a new bit onto MISO after each rising SCK edge. Word k for k≥1 is read from transmit buffer address k.
- R3: The checksum is CRC-32 with polynomial 0x04C11DB7 and seed 0xFFFFFFFF. It has no bit reflection and no final inversion. Each 16-bit word is fed MSB first, covering every data word including the length word. It is sent as two words, upper half first, right after the last data word.
- R4: After the low checksum word, the slave sends 0x0000 words until select rises.
- R5: The slave sends a clamped version of transmit buffer word 0 as its first word and uses it as its length. A value of 0 becomes 1, and a value above MAX_WORDS becomes MAX_WORDS.
- R6: MOSI is sampled on the falling SCK edge. Received data word k, with the length word as k=0, is written to receive address k only when k < MAX_WORDS. Checksum words and trailing words are never written.
- R7: One cycle pulse per session: `done` is high for exactly one clock after select rises.
- R8: If select rises before the length word, the data words and both checksum words have been received, `truncated` is 1 and `crc_ok` is 0.
- R9: `crc_ok` is 1 only when the packet is complete, the received checksum equals the CRC of the received data words, and the length word is between 1 and MAX_WORDS.
- R9 (continued): A length of 0 counts as a one-word packet. A length above MAX_WORDS still locates the checksum by the raw length, but `crc_ok` is 0.
- R10: A session that ends mid-word leaves no residue. The next session decodes and transmits from a clean start.
- R11: `crc_ok` and `truncated` hold their values after a session ends. Both clear within a few cycles after the next select fall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sck | input | 1 | SPI clock from master, idle low |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_mosi | input | 1 | Serial data from master |
| spi_miso | output | 1 | Serial data to master |
| tx_addr | output | $clog2(MAX_WORDS) | Transmit buffer read address |
| tx_data | input | 16 | Transmit buffer word at `tx_addr` |
| rx_we | output | 1 | Receive buffer write strobe |
| rx_waddr | output | $clog2(MAX_WORDS) | Receive buffer write address |
| rx_wdata | output | 16 | Receive buffer write word |
| done | output | 1 | One-cycle pulse at end of session |
| crc_ok | output | 1 | Last received packet complete and valid |
| truncated | output | 1 | Last session ended before packet end |

## Verification
The bench covers several session shapes:
- a master packet longer than the slave's, and the reverse;
- a corrupted checksum word;
- an oversize length and a zero length;
- select released after a few whole words, and after a stray partial word;
- a packet at exactly MAX_WORDS.

Each shape targets a specific defect. A slave that counts the length word wrongly would take a data word for the checksum, so MISO would run one word long or short. A design that clamps the receive length instead of using the raw count would compare the wrong words as checksum. A design without a zero pad would repeat stale words. A design that keeps bit counters across sessions would shift every word of the following packet by the leftover bits.

// File: rtl/spx_pkg.sv
package spx_pkg;
    localparam int          WORD_W   = 16;
    localparam logic [31:0] CRC_POLY = 32'h04C1_1DB7;
    localparam logic [31:0] CRC_SEED = 32'hFFFF_FFFF;

    typedef enum logic [1:0] {SES_IDLE, SES_LIVE, SES_CLOSE} ses_state_t;
    typedef enum logic [1:0] {TX_BODY, TX_SUM_HI, TX_SUM_LO, TX_PAD} tx_state_t;
    typedef enum logic [2:0] {RX_HEAD, RX_BODY, RX_SUM_HI, RX_SUM_LO, RX_TAIL} rx_state_t;

    // Advance the CRC register by one word, MSB of the word first.
    function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [WORD_W-1:0] w);
        logic [31:0] r;
        r = c;
        for (int i = WORD_W - 1; i >= 0; i--) begin
            if (r[31] ^ w[i]) r = (r << 1) ^ CRC_POLY;
            else              r = r << 1;
        end
        return r;
    endfunction
endpackage

// File: rtl/spx_sync.sv
module spx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sck_i,
    input  logic csn_i,
    input  logic mosi_i,
    output logic sck_rise,
    output logic sck_fall,
    output logic cs_fall,
    output logic cs_rise,
    output logic mosi_s
);
    localparam int NPIN = 3;
    localparam logic [NPIN-1:0] IDLE_LVL = 3'b010; // {mosi, csn, sck}

    logic [STAGES:0][NPIN-1:0] chain;
    logic [NPIN-1:0] cur, prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= {(STAGES+1){IDLE_LVL}};
        else        chain <= {chain[STAGES-1:0], {mosi_i, csn_i, sck_i}};
    end

    assign cur      = chain[STAGES-1];
    assign prev     = chain[STAGES];
    assign sck_rise =  cur[0] & ~prev[0];
    assign sck_fall = ~cur[0] &  prev[0];
    assign cs_fall  = ~cur[1] &  prev[1];
    assign cs_rise  =  cur[1] & ~prev[1];
    assign mosi_s   =  cur[2];
endmodule

// File: rtl/spx_tx.sv
module spx_tx
    import spx_pkg::*;
#(
    parameter int MAX_WORDS = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         start,
    input  logic                         live,
    input  logic                         sck_rise,
    input  logic [WORD_W-1:0]            tx_data,
    output logic [$clog2(MAX_WORDS)-1:0] tx_addr,
    output logic                         miso
);
    localparam int AW = $clog2(MAX_WORDS);
    localparam int CW = $clog2(MAX_WORDS + 1);

    tx_state_t         st;
    logic [WORD_W-1:0] sh;
    logic [3:0]        bitc;
    logic [CW-1:0]     idx, len, nxt, eff;
    logic [31:0]       crc;

    assign nxt     = idx + CW'(1);
    assign tx_addr = live ? AW'(nxt) : '0;

    always_comb begin
        if (tx_data == '0)                        eff = CW'(1);
        else if (tx_data > WORD_W'(MAX_WORDS))   eff = CW'(MAX_WORDS);
        else                                      eff = CW'(tx_data);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st <= TX_BODY; sh <= '0; bitc <= '0; idx <= '0; len <= CW'(1);
            crc <= CRC_SEED; miso <= 1'b0;
        end else if (start) begin
            st   <= TX_BODY;
            len  <= eff;
            sh   <= WORD_W'(eff);
            crc  <= crc_step(CRC_SEED, WORD_W'(eff));
            idx  <= '0;
            bitc <= '0;
            miso <= 1'b0;
        end else if (!live) begin
            miso <= 1'b0;
        end else if (sck_rise) begin
            miso <= sh[WORD_W-1];
            sh   <= sh << 1;
            bitc <= bitc + 4'd1;
            if (bitc == 4'd15) begin
                unique case (st)
                    TX_BODY: begin
                        if (nxt < len) begin
                            sh  <= tx_data;
                            crc <= crc_step(crc, tx_data);
                            idx <= nxt;
                        end else begin
                            sh <= crc[31:16];
                            st <= TX_SUM_HI;
                        end
                    end
                    TX_SUM_HI: begin sh <= crc[15:0]; st <= TX_SUM_LO; end
                    TX_SUM_LO: begin sh <= '0;        st <= TX_PAD;    end
                    TX_PAD:    sh <= '0;
                endcase
            end
        end
    end

    assert_len_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        live |-> (len != '0 && len <= CW'(MAX_WORDS)));
    assert_pad_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (live && st == TX_PAD && $past(st) == TX_PAD && $past(live)) |-> sh == '0);
endmodule

// File: rtl/spx_rx.sv
module spx_rx
    import spx_pkg::*;
#(
    parameter int MAX_WORDS = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         start,
    input  logic                         live,
    input  logic                         sck_fall,
    input  logic                         mosi,
    output logic                         rx_we,
    output logic [$clog2(MAX_WORDS)-1:0] rx_waddr,
    output logic [WORD_W-1:0]            rx_wdata,
    output logic                         complete,
    output logic                         sum_match,
    output logic                         len_bad
);
    localparam int AW = $clog2(MAX_WORDS);

    rx_state_t         st;
    logic [WORD_W-1:0] sh, w, sum_hi, total, widx;
    logic [3:0]        bitc;
    logic [31:0]       crc;

    assign w        = {sh[WORD_W-2:0], mosi};
    assign complete = (st == RX_TAIL);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st <= RX_HEAD; sh <= '0; bitc <= '0; widx <= '0; total <= '0;
            sum_hi <= '0; crc <= CRC_SEED; sum_match <= 1'b0; len_bad <= 1'b0;
            rx_we <= 1'b0; rx_waddr <= '0; rx_wdata <= '0;
        end else begin
            rx_we <= 1'b0;
            if (start) begin
                st <= RX_HEAD; bitc <= '0; widx <= '0; crc <= CRC_SEED;
                sum_match <= 1'b0; len_bad <= 1'b0;
            end else if (live && sck_fall) begin
                sh   <= w;
                bitc <= bitc + 4'd1;
                if (bitc == 4'd15) begin
                    unique case (st)
                        RX_HEAD: begin
                            total    <= (w == '0) ? WORD_W'(1) : w;
                            len_bad  <= (w == '0) || (w > WORD_W'(MAX_WORDS));
                            crc      <= crc_step(crc, w);
                            rx_we    <= 1'b1;
                            rx_waddr <= '0;
                            rx_wdata <= w;
                            widx     <= WORD_W'(1);
                            st       <= (w <= WORD_W'(1)) ? RX_SUM_HI : RX_BODY;
                        end
                        RX_BODY: begin
                            crc <= crc_step(crc, w);
                            if (widx < WORD_W'(MAX_WORDS)) begin
                                rx_we    <= 1'b1;
                                rx_waddr <= AW'(widx);
                                rx_wdata <= w;
                            end
                            widx <= widx + WORD_W'(1);
                            if (widx + WORD_W'(1) == total) st <= RX_SUM_HI;
                        end
                        RX_SUM_HI: begin sum_hi <= w; st <= RX_SUM_LO; end
                        RX_SUM_LO: begin sum_match <= ({sum_hi, w} == crc); st <= RX_TAIL; end
                        RX_TAIL: ;
                    endcase
                end
            end
        end
    end

    assert_wr_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rx_we |-> (32'(rx_waddr) < MAX_WORDS));
    assert_no_wr_tail_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(st) == RX_SUM_HI || $past(st) == RX_SUM_LO || $past(st) == RX_TAIL) |-> !rx_we);
endmodule

// File: rtl/spi_pkt_slave.sv
module spi_pkt_slave
    import spx_pkg::*;
#(
    parameter int MAX_WORDS   = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         spi_sck,
    input  logic                         spi_cs_n,
    input  logic                         spi_mosi,
    output logic                         spi_miso,
    output logic [$clog2(MAX_WORDS)-1:0] tx_addr,
    input  logic [15:0]                  tx_data,
    output logic                         rx_we,
    output logic [$clog2(MAX_WORDS)-1:0] rx_waddr,
    output logic [15:0]                  rx_wdata,
    output logic                         done,
    output logic                         crc_ok,
    output logic                         truncated
);
    logic sck_rise, sck_fall, cs_fall, cs_rise, mosi_s;
    logic start, live, complete, sum_match, len_bad;
    ses_state_t ses, ses_nx;

    spx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .sck_i(spi_sck), .csn_i(spi_cs_n), .mosi_i(spi_mosi),
        .sck_rise(sck_rise), .sck_fall(sck_fall), .cs_fall(cs_fall), .cs_rise(cs_rise),
        .mosi_s(mosi_s));

    assign start = (ses == SES_IDLE) && cs_fall;
    assign live  = (ses == SES_LIVE);

    spx_tx #(.MAX_WORDS(MAX_WORDS)) u_tx (
        .clk(clk), .rst_n(rst_n), .start(start), .live(live), .sck_rise(sck_rise),
        .tx_data(tx_data), .tx_addr(tx_addr), .miso(spi_miso));

    spx_rx #(.MAX_WORDS(MAX_WORDS)) u_rx (
        .clk(clk), .rst_n(rst_n), .start(start), .live(live), .sck_fall(sck_fall),
        .mosi(mosi_s), .rx_we(rx_we), .rx_waddr(rx_waddr), .rx_wdata(rx_wdata),
        .complete(complete), .sum_match(sum_match), .len_bad(len_bad));

    always_comb begin
        ses_nx = ses;
        unique case (ses)
            SES_IDLE:  if (cs_fall) ses_nx = SES_LIVE;
            SES_LIVE:  if (cs_rise) ses_nx = SES_CLOSE;
            SES_CLOSE: ses_nx = SES_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ses <= SES_IDLE;
        else        ses <= ses_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            crc_ok <= 1'b0; truncated <= 1'b0;
        end else if (start) begin
            crc_ok <= 1'b0; truncated <= 1'b0;
        end else if (live && cs_rise) begin
            truncated <= !complete;
            crc_ok    <= complete && sum_match && !len_bad;
        end
    end

    assign done = (ses == SES_CLOSE);

    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_flags_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
        crc_ok |-> !truncated);
    assert_flags_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (!crc_ok && !truncated));
endmodule

// File: tb/tb_spi_pkt_slave.sv
module tb_spi_pkt_slave;
    localparam int MAXW = 16;
    localparam int AW   = 4;
    localparam int HALF = 10; // system clocks per SPI half period

    logic clk = 1'b0, rst_n = 1'b0;
    logic spi_sck = 1'b0, spi_cs_n = 1'b1, spi_mosi = 1'b0;
    logic spi_miso, rx_we, done, crc_ok, truncated;
    logic [AW-1:0] tx_addr, rx_waddr;
    logic [15:0] tx_data, rx_wdata;
    logic [15:0] txmem [MAXW];
    logic [15:0] m_out [32];
    logic [15:0] m_in  [32];
    logic [15:0] s_exp [32];
    logic [AW+15:0] exp_wr [$];
    int total = 0, bad = 0, n_done = 0;

    always #2 clk = ~clk;
    assign tx_data = txmem[tx_addr];

    spi_pkt_slave #(.MAX_WORDS(MAXW)) dut (
        .clk(clk), .rst_n(rst_n), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso), .tx_addr(tx_addr), .tx_data(tx_data),
        .rx_we(rx_we), .rx_waddr(rx_waddr), .rx_wdata(rx_wdata), .done(done),
        .crc_ok(crc_ok), .truncated(truncated));

    function automatic logic [31:0] crc16w(input logic [31:0] c, input logic [15:0] w);
        logic [31:0] r = c;
        for (int i = 15; i >= 0; i--) r = (r[31] ^ w[i]) ? ((r << 1) ^ 32'h04C11DB7) : (r << 1);
        return r;
    endfunction

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Monitor: pops expected receive-buffer writes as the design produces them (R6)
    always @(negedge clk) begin
        if (rst_n) begin
            if (done) n_done++;
            if (rx_we) begin
                if (exp_wr.size() == 0) check(0, "R6 unexpected write", {rx_waddr, rx_wdata}, 0);
                else begin
                    automatic logic [AW+15:0] e = exp_wr.pop_front();
                    check({rx_waddr, rx_wdata} == e, "R6 write", {rx_waddr, rx_wdata}, e);
                end
            end
        end
    end

    // Driver: builds master packet and queues expected writes (up to wlimit words sent)
    task automatic make_master(input int len_field, input int ndata, input bit corrupt, input int wlimit);
        logic [31:0] c = 32'hFFFFFFFF;
        for (int i = 0; i < 32; i++) m_out[i] = '0;
        for (int i = 0; i < ndata; i++) begin
            m_out[i] = (i == 0) ? 16'(len_field) : 16'((i * 16'h3A15) ^ 16'hC0DE);
            c = crc16w(c, m_out[i]);
            if (i < MAXW && i < wlimit) exp_wr.push_back({AW'(i), m_out[i]});
        end
        m_out[ndata]   = c[31:16];
        m_out[ndata+1] = c[15:0] ^ {15'd0, corrupt};
    endtask

    // Expected slave stream from the transmit buffer (R2, R3, R4, R5)
    task automatic make_slave();
        logic [31:0] c = 32'hFFFFFFFF;
        int eff = (txmem[0] == 0) ? 1 : (txmem[0] > MAXW) ? MAXW : int'(txmem[0]);
        for (int i = 0; i < 32; i++) s_exp[i] = '0;
        for (int i = 0; i < eff; i++) begin
            s_exp[i] = (i == 0) ? 16'(eff) : txmem[i];
            c = crc16w(c, s_exp[i]);
        end
        s_exp[eff]   = c[31:16];
        s_exp[eff+1] = c[15:0];
    endtask

    task automatic bit_cycle(input logic b, input int w, input int k, input bit cap);
        spi_mosi = b; spi_sck = 1'b1;
        repeat (HALF) @(negedge clk);
        if (cap) m_in[w][k] = spi_miso;
        spi_sck = 1'b0;
        repeat (HALF) @(negedge clk);
    endtask

    task automatic session(input int nw, input int extra_bits);
        spi_cs_n = 1'b0;
        repeat (10) @(negedge clk);
        check(!crc_ok && !truncated, "R11 flags cleared at select", {crc_ok, truncated}, 0);
        for (int w = 0; w < nw; w++)
            for (int k = 15; k >= 0; k--) bit_cycle(m_out[w][k], w, k, 1'b1);
        for (int k = 0; k < extra_bits; k++) bit_cycle(1'b1, 0, 0, 1'b0);
        spi_cs_n = 1'b1;
        repeat (40) @(negedge clk);
    endtask

    task automatic finish_session(input string tag, input int ncheck, input int done_before,
                                  input bit exp_ok, input bit exp_tr);
        int mism = 0, first = -1;
        for (int i = 0; i < ncheck; i++) if (m_in[i] !== s_exp[i]) begin mism++; if (first < 0) first = i; end
        check(mism == 0, {tag, " R2 R3 R4 R5 miso stream"},
              (first < 0) ? 0 : m_in[first], (first < 0) ? 0 : s_exp[first]);
        check(n_done == done_before + 1, {tag, " R7 done pulse"}, n_done - done_before, 1);
        check(crc_ok == exp_ok, {tag, " R9 crc_ok"}, crc_ok, exp_ok);
        check(truncated == exp_tr, {tag, " R8 truncated"}, truncated, exp_tr);
        check(exp_wr.size() == 0, {tag, " R6 all writes seen"}, exp_wr.size(), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        check(0, "watchdog", 0, 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int d;
        for (int i = 0; i < MAXW; i++) txmem[i] = 16'h5000 + 16'(i * 16'h0111);
        repeat (5) @(negedge clk);
        check(!done && !crc_ok && !truncated && !rx_we && !spi_miso, "R1 reset state",
              {done, crc_ok, truncated, rx_we, spi_miso}, 0);
        rst_n = 1'b1;
        repeat (10) @(negedge clk);

        // S1: master 4 words, slave 3 words; slave pads (R4)
        txmem[0] = 16'd3; make_slave(); make_master(4, 4, 0, 99); d = n_done;
        session(7, 0); finish_session("S1", 7, d, 1, 0);
        check(crc_ok, "R11 flags held after session", crc_ok, 1);

        // S2: slave longer than master, master checksum corrupted (R9)
        txmem[0] = 16'd6; make_slave(); make_master(2, 2, 1, 99); d = n_done;
        session(9, 0); finish_session("S2", 9, d, 0, 0);

        // S3: oversize lengths on both sides (R5, R9, R6 discard)
        txmem[0] = 16'd20; make_slave(); make_master(20, 20, 0, 99); d = n_done;
        session(23, 0); finish_session("S3", 23, d, 0, 0);

        // S4: select released after three words (R8)
        txmem[0] = 16'd5; make_slave(); make_master(5, 5, 0, 3); d = n_done;
        session(3, 0); finish_session("S4", 3, d, 0, 1);

        // S5: stray partial word at end (R8, R10)
        txmem[0] = 16'd2; make_slave(); make_master(3, 3, 0, 1); d = n_done;
        session(1, 5); finish_session("S5", 1, d, 0, 1);

        // S6: zero length on both sides, recovery after partial word (R5, R9, R10)
        txmem[0] = 16'd0; make_slave(); make_master(0, 1, 0, 99); d = n_done;
        session(4, 0); finish_session("S6 R10", 4, d, 0, 0);

        // S7: exactly MAX_WORDS on both sides
        txmem[0] = 16'(MAXW); make_slave(); make_master(MAXW, MAXW, 0, 99); d = n_done;
        session(19, 0); finish_session("S7 R10", 19, d, 1, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule